// File: doc/BRIEF.md
# PIO Channel Access Sequencer

This block runs the channel-access command of a two-channel open-drain PIO slave on a single-wire bus. A bit engine decodes the command byte, raises `cmd_hit`, and then offers one pulse on `slot` per bit time slot. For each slot it passes the bit the master wrote (`bit_in`). When `rd_req` is high, the engine drives `rd_bit` onto the line instead.

After the command the sequencer takes two control bytes. It answers with a channel info byte, then streams data. In write slots the data goes into the output flip-flops. In read slots it comes from the sensed pin levels. The control byte sets which channels take part and how two channels share slots. It also sets whether the direction flips after every byte, and how often a CRC16 is sent.

A bus reset from the engine returns the sequencer to idle from any state.

Top module: `pio_chan_seq`

## Requirements
- R1: After reset, `ff_a` and `ff_b` are 1 (transistors off), `rd_req` is 0 and `latch_clr` is 0.
- R2: The two control bytes arrive LSB first, control byte 2 being FFh. The next 8 slots are read slots returning the info byte LSB first. Its layout, bit 7 down to bit 0, is: supply_ok, has_b, act_b, act_a, pin_b, pin_a, ff_b, ff_a. All of these are sampled at the last slot of control byte 2.
- R3: Control byte 1 has these fields: bit 7 = clear activity latches, bit 6 = start in read mode (1) or write mode (0), bit 5 = toggle, bit 4 = synchronous two-channel mode, bits 3:2 = channel select, bits 1:0 = CRC interval. `latch_clr` pulses for exactly one cycle at the end of control byte 2 when bit 7 is 1, and never when bit 7 is 0.
- R4: Channel select 00 leaves `rd_req` at 0 and both flip-flops unchanged for every later slot until a bus reset.
- R5: Single channel (select 01 = A, 10 = B): a read slot returns the pin level present in that slot, and a write slot loads `bit_in` into that channel's flip-flop.
- R6: Select 11 uses both channels in turn, starting with A. In alternating mode (bit 4 = 0) each slot reads its own pin or updates its own flip-flop at once.
- R7: In a synchronous two-channel read, both pins are sampled in A's slot, and B's slot returns the B level held from that sample.
- R8: In a synchronous two-channel write, neither flip-flop changes in A's slot. Both update together at B's slot.
- R9: With toggle set, the direction flips after every 8-slot data byte. If a CRC is due, the flip happens after that CRC.
- R10: The CRC interval code is 00 = never, 01 = after every byte, 10 = after 8 bytes, 11 = after 32 bytes. A CRC occupies 16 read slots.
- R11: The CRC16 uses x^16+x^15+x^2+1 (reflected), starts from 0 and is sent inverted, LSB first. The first CRC covers the command byte (F5h), both control bytes and the data. Each later CRC covers only the data since the previous CRC.
- R12: `bus_reset` returns the block to idle: from the next cycle `rd_req` is 0 and slots are ignored until `cmd_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | Bus reset seen by the bit engine |
| cmd_hit | input | 1 | Channel-access command byte received |
| slot | input | 1 | One-cycle pulse per bit time slot |
| bit_in | input | 1 | Bit written by the master in this slot |
| pin_a | input | 1 | Sensed level of pin A |
| pin_b | input | 1 | Sensed level of pin B |
| act_a | input | 1 | Activity latch A |
| act_b | input | 1 | Activity latch B |
| supply_ok | input | 1 | External supply present |
| has_b | input | 1 | Channel B is bonded out |
| rd_req | output | 1 | This slot is a slave-driven read slot |
| rd_bit | output | 1 | Bit to send in a read slot |
| ff_a | output | 1 | Channel A flip-flop (0 = conducting) |
| ff_b | output | 1 | Channel B flip-flop (0 = conducting) |
| latch_clr | output | 1 | Clears both activity latches |

## Verification
Pin levels and written data are drawn at random and driven slot by slot. This separates true per-slot sampling from held values. The synchronous read changes pin B between A's and B's slot, so a design that samples B late returns the wrong bit. The synchronous write checks that the flip-flops are unchanged after A's slot, which catches an update that comes too early. The CRC runs cover codes 01, 10 and 11 plus a run with no CRC. Together they show whether the command and control bytes are folded into the first CRC only, and whether toggling waits for the CRC.

// File: rtl/pio_chan_seq.sv
module pio_chan_seq #(
  parameter logic [7:0] CMD_CODE = 8'hF5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic cmd_hit,
  input  logic slot,
  input  logic bit_in,
  input  logic pin_a,
  input  logic pin_b,
  input  logic act_a,
  input  logic act_b,
  input  logic supply_ok,
  input  logic has_b,
  output logic rd_req,
  output logic rd_bit,
  output logic ff_a,
  output logic ff_b,
  output logic latch_clr
);

  typedef enum logic [2:0] {S_IDLE, S_CTL1, S_CTL2, S_INFO, S_DATA, S_CRC, S_DEAD} st_t;

  st_t         st;
  logic [3:0]  cnt;
  logic [5:0]  nbytes;
  logic [5:0]  span;
  logic [7:0]  ctl, sh, info;
  logic [15:0] crc;
  logic        rd_mode, hold;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = {1'b0, c[15:1]};
    if (c[0] ^ b) n = n ^ 16'hA001;
    return n;
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] n;
    n = c;
    for (int i = 0; i < 8; i++) n = crc_step(n, v[i]);
    return n;
  endfunction

  wire [1:0] sel      = ctl[3:2];
  wire       both     = &sel;
  wire       sync     = ctl[4] & both;
  wire       on_b     = both ? cnt[0] : sel[1];
  wire       last_bit = cnt[2:0] == 3'd7;
  wire       dread    = (sync && on_b) ? hold : (on_b ? pin_b : pin_a);
  wire       dbit     = rd_mode ? dread : bit_in;

  always_comb begin
    case (ctl[1:0])
      2'b01:   span = 6'd1;
      2'b10:   span = 6'd8;
      default: span = 6'd32;
    endcase
  end

  wire crc_due = (ctl[1:0] != 2'b00) && (nbytes + 6'd1 == span);

  assign rd_req = (st == S_INFO) || (st == S_CRC) || (st == S_DATA && rd_mode);
  assign rd_bit = (st == S_INFO) ? info[cnt[2:0]] :
                  (st == S_CRC)  ? ~crc[cnt] :
                  (st == S_DATA && rd_mode) ? dread : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbytes <= '0; ctl <= '0; sh <= '0; info <= '0;
      crc <= '0; rd_mode <= 1'b0; hold <= 1'b0; ff_a <= 1'b1; ff_b <= 1'b1;
      latch_clr <= 1'b0;
    end else begin
      latch_clr <= 1'b0;
      if (bus_reset) begin
        st <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (cmd_hit) begin
            st  <= S_CTL1;
            cnt <= '0;
            crc <= crc_byte(16'h0000, CMD_CODE);
          end
          S_CTL1, S_CTL2: if (slot) begin
            sh  <= {bit_in, sh[7:1]};
            crc <= crc_step(crc, bit_in);
            cnt <= cnt + 4'd1;
            if (last_bit) begin
              cnt <= '0;
              if (st == S_CTL1) begin
                ctl <= {bit_in, sh[7:1]};
                st  <= S_CTL2;
              end else begin
                info      <= {supply_ok, has_b, act_b, act_a, pin_b, pin_a, ff_b, ff_a};
                latch_clr <= ctl[7];
                rd_mode   <= ctl[6];
                nbytes    <= '0;
                st        <= (sel == 2'b00) ? S_DEAD : S_INFO;
              end
            end
          end
          S_INFO: if (slot) begin
            cnt <= cnt + 4'd1;
            if (last_bit) begin
              cnt <= '0;
              st  <= S_DATA;
            end
          end
          S_DATA: if (slot) begin
            crc <= crc_step(crc, dbit);
            cnt <= cnt + 4'd1;
            if (sync && !on_b) hold <= rd_mode ? pin_b : bit_in;
            if (!rd_mode) begin
              if (!on_b && !sync) ff_a <= bit_in;
              if (on_b) ff_b <= bit_in;
              if (on_b && sync) ff_a <= hold;
            end
            if (last_bit) begin
              cnt <= '0;
              if (crc_due) begin
                st     <= S_CRC;
                nbytes <= '0;
              end else begin
                nbytes <= nbytes + 6'd1;
                if (ctl[5]) rd_mode <= ~rd_mode;
              end
            end
          end
          S_CRC: if (slot) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              cnt <= '0;
              crc <= '0;
              st  <= S_DATA;
              if (ctl[5]) rd_mode <= ~rd_mode;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_dead_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DEAD |=> $stable(ff_a) && $stable(ff_b));

  p_clr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> !latch_clr);

  p_sync_a_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && slot && !rd_mode && sync && !on_b && !bus_reset)
      |=> $stable(ff_a) && $stable(ff_b));

  p_bus_reset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !rd_req);

endmodule

// File: tb/test_pio_chan_seq.sv
module test_pio_chan_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bus_reset = 0, cmd_hit = 0, slot = 0, bit_in = 0;
  logic pin_a = 0, pin_b = 0, act_a = 0, act_b = 0, supply_ok = 0, has_b = 0;
  logic rd_req, rd_bit, ff_a, ff_b, latch_clr;

  int nchk = 0, nerr = 0, nclr = 0;
  logic [15:0] mcrc;
  logic r, q;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (latch_clr) nclr++;

  pio_chan_seq i_pio_chan_seq (.*);

  function automatic logic [15:0] m_step(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = {1'b0, c[15:1]};
    if (c[0] ^ b) n = n ^ 16'hA001;
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic slot_io(input logic b, output logic rb, output logic rq);
    @(negedge clk); slot = 1; bit_in = b;
    #1; rb = rd_bit; rq = rd_req;
    @(negedge clk); slot = 0;
  endtask

  task automatic mshift(input logic [7:0] v);
    for (int i = 0; i < 8; i++) mcrc = m_step(mcrc, v[i]);
  endtask

  task automatic begin_cmd(input logic [7:0] c1, output logic [7:0] inf);
    logic rb, rq;
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0; cmd_hit = 1;
    @(negedge clk); cmd_hit = 0;
    mcrc = 16'h0; mshift(8'hF5); mshift(c1); mshift(8'hFF);
    for (int i = 0; i < 8; i++) slot_io(c1[i], rb, rq);
    for (int i = 0; i < 8; i++) slot_io(1'b1, rb, rq);
    for (int i = 0; i < 8; i++) begin slot_io(1'b1, rb, rq); inf[i] = rb; end
  endtask

  task automatic read_crc(input string tag);
    logic rb, rq;
    for (int i = 0; i < 16; i++) begin
      slot_io(1'b1, rb, rq);
      check({tag, " crc bit"}, {rq, rb}, {1'b1, ~mcrc[i]});
    end
    mcrc = 16'h0;
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog R12 got=hung exp=done");
    finish_up();
  end

  initial begin
    logic [7:0] inf, expi, d;
    logic pa, pb, oa, ob;
    int c0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", {ff_a, ff_b, rd_req, latch_clr}, 4'b1100);
    rst_n = 1;

    // single A read, no CRC, no clear
    supply_ok = 1; has_b = 1; act_a = 1; act_b = 0; pin_a = 1; pin_b = 0;
    c0 = nclr;
    expi = {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    begin_cmd(8'h44, inf);
    check("R2 info byte", inf, expi);
    @(negedge clk);
    check("R3 no clear pulse", nclr - c0, 0);
    for (int i = 0; i < 24; i++) begin
      pa = 1'($urandom); pin_a = pa; pin_b = ~pa;
      slot_io(1'b0, r, q);
      check("R5 single A read", {q, r}, {1'b1, pa});
    end
    // R12: bus reset mid-stream
    @(negedge clk); bus_reset = 1; @(negedge clk); bus_reset = 0;
    slot_io(1'b0, r, q);
    check("R12 idle after bus reset", q, 0);

    // single A write, CRC every byte
    begin_cmd(8'h05, inf);
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        slot_io(d[i], r, q);
        #1 check("R5 single A write", {q, ff_a}, {1'b0, d[i]});
      end
      mshift(d);
      read_crc("R11 R10 every byte");
    end

    // single B read with different info pins
    supply_ok = 0; has_b = 0; act_a = 0; act_b = 1; pin_a = 0; pin_b = 1;
    expi = {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, ff_b, ff_a};
    begin_cmd(8'h48, inf);
    check("R2 info byte 2", inf, expi);
    for (int i = 0; i < 8; i++) begin
      pb = 1'($urandom); pin_b = pb; pin_a = ~pb;
      slot_io(1'b0, r, q);
      check("R5 single B read", r, pb);
    end

    // both channels, synchronous write
    begin_cmd(8'h1C, inf);
    for (int k = 0; k < 2; k++) begin
      d = 8'($urandom);
      for (int i = 0; i < 8; i += 2) begin
        oa = ff_a; ob = ff_b;
        slot_io(d[i], r, q);
        #1 check("R8 sync write A slot holds", {ff_a, ff_b}, {oa, ob});
        slot_io(d[i+1], r, q);
        #1 check("R8 sync write both update", {ff_a, ff_b}, {d[i], d[i+1]});
      end
    end

    // both channels alternating, read first, toggle
    begin_cmd(8'h6C, inf);
    for (int i = 0; i < 8; i++) begin
      pa = 1'($urandom); pb = 1'($urandom); pin_a = pa; pin_b = pb;
      slot_io(1'b0, r, q);
      check("R6 alternating read", {q, r}, {1'b1, (i % 2 == 0) ? pa : pb});
    end
    d = 8'($urandom);
    for (int i = 0; i < 8; i++) begin
      oa = ff_a; ob = ff_b;
      slot_io(d[i], r, q);
      #1;
      check("R9 toggled to write", q, 0);
      if (i % 2 == 0) check("R6 alternating write A", {ff_a, ff_b}, {d[i], ob});
      else            check("R6 alternating write B", {ff_a, ff_b}, {oa, d[i]});
    end
    slot_io(1'b0, r, q);
    check("R9 toggled back to read", q, 1);

    // both channels, synchronous read
    begin_cmd(8'h5C, inf);
    for (int i = 0; i < 4; i++) begin
      pa = 1'($urandom); pb = 1'($urandom); pin_a = pa; pin_b = pb;
      slot_io(1'b0, r, q);
      check("R7 sync read A", r, pa);
      pin_b = ~pb;
      slot_io(1'b0, r, q);
      check("R7 sync read B held", r, pb);
    end

    // B only write, CRC after 8 bytes, toggle waits for CRC
    begin_cmd(8'h2A, inf);
    for (int k = 0; k < 8; k++) begin
      d = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        slot_io(d[i], r, q);
        if (k % 2 == 1) d[i] = r;
        if (i == 0) check("R9 direction per byte", q, k % 2);
        if (k % 2 == 0) #1 check("R5 single B write", ff_b, d[i]);
      end
      mshift(d);
      if (k == 7) read_crc("R11 R10 after 8 bytes");
    end
    slot_io(1'b1, r, q);
    check("R9 toggle after CRC", q, 0);

    // B only write, CRC after 32 bytes (second CRC covers data only)
    begin_cmd(8'h0B, inf);
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 32; k++) begin
        d = 8'($urandom);
        for (int i = 0; i < 8; i++) begin
          slot_io(d[i], r, q);
          if (i == 0 && k == 31) check("R10 no CRC before 32", q, 0);
        end
        mshift(d);
      end
      read_crc("R11 R10 after 32 bytes");
    end

    // no CRC: write never interrupted
    begin_cmd(8'h04, inf);
    for (int k = 0; k < 40; k++) begin
      d = 8'($urandom);
      for (int i = 0; i < 8; i++) slot_io(d[i], r, q);
      if (k == 39) check("R10 no CRC code 00", q, 0);
    end

    // channel select 00 with latch clear
    c0 = nclr;
    begin_cmd(8'hC0, inf);
    @(negedge clk);
    check("R3 clear pulse", nclr - c0, 1);
    oa = ff_a; ob = ff_b;
    for (int i = 0; i < 12; i++) begin
      slot_io(~ff_a, r, q);
      check("R4 select 00 no read", q, 0);
    end
    check("R4 select 00 ff unchanged", {ff_a, ff_b}, {oa, ob});

    finish_up();
  end
endmodule